// File: doc/BRIEF.md
# Two-Color Cell Texel Decoder

This block turns one compressed texture cell into the color of a single texel. A cell covers a 4x4 patch of texels and is packed into a 32-bit word. The word carries two 8-bit palette indices and sixteen selection bits, one bit per texel. The block reads the two indexed colors from an internal 256-entry palette of 24-bit RGB values. It then uses the texel's selection bit to pick one of them.

Every texel decodes on its own. The result depends only on the word, the texel number and the palette, so a texture fetch unit can reach any texel of any cell at random, at a cost of two bits per texel. The palette is filled through a synchronous write port.

A request is presented with `in_valid` for one cycle. The color appears one cycle later, together with `out_valid`. Both candidate colors of the cell can also be brought out, so that a neighbouring selector can resolve a second texel of the same cell in that cycle.

The output stage is a two-state machine:
- `ST_IDLE`: no result is held, and all color outputs are zero.
- `ST_SHOW`: a result is presented.

Its transitions are:
- `IDLE->SHOW` or `SHOW->SHOW` at any edge where `in_valid` is high.
- `SHOW->IDLE` or `IDLE->IDLE` at any edge where `in_valid` is low.

Top module: `cell_texel_decoder`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted and after it is released, before any request arrives, `out_valid` is 0 and `out_rgb`, `out_cand0` and `out_cand1` are 0.
- R2: `out_valid` is high in the cycle after each edge at which `in_valid` was high, and low in the cycle after each edge at which it was low.
- R3: Field layout of the cell word:
  - bits [31:24] hold palette index 0;
  - bits [23:16] hold palette index 1;
  - bits [15:0] hold the selection bits.
  When both indices are equal, the two candidate colors are equal.
- R4: Texel t (0..15) is the texel at row t/4, column t%4, and its selection bit is word bit t. A bit value of 1 yields the palette color at index 1, and a value of 0 yields the color at index 0.
- R5: While `out_valid` is low, `out_rgb`, `out_cand0` and `out_cand1` are all 0.
- R6: A palette write with `wr_en` high stores `wr_data` at `wr_addr` at the clock edge. Any read issued at a later edge returns the new value.
- R7: A request accepted at the same edge as a write to the entry it reads returns the entry's value from before that write.
- R8: With `PAIR_OUT`=1, `out_cand0` and `out_cand1` present the palette colors at index 0 and index 1 of the cell, alongside `out_rgb`.
- R9: Requests on consecutive cycles are each decoded from their own word and texel number, with no influence from the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Palette write strobe |
| wr_addr | input | 8 | Palette entry to write |
| wr_data | input | 24 | RGB value to store |
| in_valid | input | 1 | Request qualifier |
| in_word | input | 32 | Compressed cell word |
| in_texel | input | 4 | Texel number inside the cell, row-major |
| out_valid | output | 1 | Result qualifier, one cycle after the request |
| out_rgb | output | 24 | Decoded texel color |
| out_cand0 | output | 24 | Palette color at index 0 of the cell |
| out_cand1 | output | 24 | Palette color at index 1 of the cell |

## Verification
The checker watches four things on every cycle:
- `out_valid` follows `in_valid` by one cycle.
- The color outputs are zero while no result is shown.
- The decoded color is the candidate chosen by the selection bit of the previous request.
- Equal indices give equal candidates.

The bench has to show the rest:
- That the candidates are the right palette entries for the right fields.
- That a write becomes visible only at the next read.
- That a same-edge read sees the old value.
- The exact reset values.

It does this with a fully computed palette, a sweep over all sixteen texels for many cells, and back-to-back requests.

// File: rtl/ctd_pkg.sv
package ctd_pkg;

    localparam int unsigned CTD_IDX_W   = 8;
    localparam int unsigned CTD_COLOR_W = 24;
    localparam int unsigned CTD_SEL_N   = 16;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } ctd_state_e;

endpackage

// File: rtl/ctd_palette.sv
module ctd_palette #(
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned COLOR_W = 24
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [COLOR_W-1:0] wr_data,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_addr0,
    input  logic [IDX_W-1:0]   rd_addr1,
    output logic [COLOR_W-1:0] rd_data0,
    output logic [COLOR_W-1:0] rd_data1
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [COLOR_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Reads sample the array before this edge's write lands: old value on collision.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data0 <= mem[rd_addr0];
            rd_data1 <= mem[rd_addr1];
        end
    end
endmodule

// File: rtl/ctd_field_split.sv
module ctd_field_split #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned SEL_N = 16,
    localparam int unsigned WORD_W = 2*IDX_W + SEL_N,
    localparam int unsigned TEX_W  = $clog2(SEL_N)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [TEX_W-1:0]  texel,
    output logic [IDX_W-1:0]  idx0,
    output logic [IDX_W-1:0]  idx1,
    output logic              pick
);
    logic [SEL_N-1:0] sel_bits;

    always_comb begin
        idx0     = word[WORD_W-1 -: IDX_W];
        idx1     = word[WORD_W-IDX_W-1 -: IDX_W];
        sel_bits = word[SEL_N-1:0];
        pick     = sel_bits[texel];
    end
endmodule

// File: rtl/cell_texel_decoder.sv
module cell_texel_decoder
    import ctd_pkg::*;
#(
    parameter int unsigned IDX_W    = CTD_IDX_W,
    parameter int unsigned COLOR_W  = CTD_COLOR_W,
    parameter int unsigned SEL_N    = CTD_SEL_N,
    parameter bit          PAIR_OUT = 1'b1,
    localparam int unsigned WORD_W  = 2*IDX_W + SEL_N,
    localparam int unsigned TEX_W   = $clog2(SEL_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [COLOR_W-1:0] wr_data,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_word,
    input  logic [TEX_W-1:0]   in_texel,
    output logic               out_valid,
    output logic [COLOR_W-1:0] out_rgb,
    output logic [COLOR_W-1:0] out_cand0,
    output logic [COLOR_W-1:0] out_cand1
);
    logic [IDX_W-1:0]   idx0, idx1;
    logic               pick;
    logic               pick_q;
    logic [COLOR_W-1:0] col0, col1;
    ctd_state_e         state_q, state_d;

    ctd_field_split #(.IDX_W(IDX_W), .SEL_N(SEL_N)) u_split (
        .word  (in_word),
        .texel (in_texel),
        .idx0  (idx0),
        .idx1  (idx1),
        .pick  (pick)
    );

    ctd_palette #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_pal (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (in_valid),
        .rd_addr0 (idx0),
        .rd_addr1 (idx1),
        .rd_data0 (col0),
        .rd_data1 (col1)
    );

    always_comb begin
        state_d = in_valid ? ST_SHOW : ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pick_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                pick_q <= pick;
            end
        end
    end

    logic [COLOR_W-1:0] cand0_w, cand1_w;

    always_comb begin
        out_valid = 1'b0;
        out_rgb   = '0;
        cand0_w   = '0;
        cand1_w   = '0;
        unique case (state_q)
            ST_IDLE: begin
                out_valid = 1'b0;
            end
            ST_SHOW: begin
                out_valid = 1'b1;
                out_rgb   = pick_q ? col1 : col0;
                cand0_w   = col0;
                cand1_w   = col1;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

    generate
        if (PAIR_OUT) begin : g_pair
            assign out_cand0 = cand0_w;
            assign out_cand1 = cand1_w;
        end else begin : g_single
            logic unused_cands;
            assign unused_cands = ^{cand0_w, cand1_w};
            assign out_cand0 = '0;
            assign out_cand1 = '0;
        end
    endgenerate
endmodule

// File: rtl/ctd_checker.sv
module ctd_checker #(
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned COLOR_W  = 24,
    parameter int unsigned SEL_N    = 16,
    parameter bit          PAIR_OUT = 1'b1,
    localparam int unsigned WORD_W  = 2*IDX_W + SEL_N,
    localparam int unsigned TEX_W   = $clog2(SEL_N)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [WORD_W-1:0]  in_word,
    input logic [TEX_W-1:0]   in_texel,
    input logic               out_valid,
    input logic [COLOR_W-1:0] out_rgb,
    input logic [COLOR_W-1:0] out_cand0,
    input logic [COLOR_W-1:0] out_cand1
);
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_rgb == '0 && out_cand0 == '0 && out_cand1 == '0));

    generate
        if (PAIR_OUT) begin : g_pair_chk
            p_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (out_rgb == ($past(in_word[in_texel]) ? out_cand1 : out_cand0)));

            p_same_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_word[WORD_W-1 -: IDX_W] == in_word[WORD_W-IDX_W-1 -: IDX_W])
                |=> (out_cand0 == out_cand1));
        end
    endgenerate
endmodule

bind cell_texel_decoder ctd_checker #(
    .IDX_W(IDX_W), .COLOR_W(COLOR_W), .SEL_N(SEL_N), .PAIR_OUT(PAIR_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_texel  (in_texel),
    .out_valid (out_valid),
    .out_rgb   (out_rgb),
    .out_cand0 (out_cand0),
    .out_cand1 (out_cand1)
);

// File: tb/cell_texel_decoder_tb.sv
`timescale 1ns/1ps
module cell_texel_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [3:0]  in_texel = '0;
    logic        out_valid;
    logic [23:0] out_rgb, out_cand0, out_cand1;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;
    logic [23:0] model [256];

    always #2 clk = ~clk;

    cell_texel_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .in_valid(in_valid), .in_word(in_word), .in_texel(in_texel),
        .out_valid(out_valid), .out_rgb(out_rgb), .out_cand0(out_cand0), .out_cand1(out_cand1)
    );

    function automatic logic [23:0] pal_val(input int a);
        logic [7:0] b;
        b = a[7:0];
        return {b, ~b, b ^ 8'h5A};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one request, then check the result one edge later (R2, R3, R4, R8).
    task automatic decode_one(input logic [31:0] w, input int t, input string req);
        logic [23:0] c0, c1;
        @(negedge clk);
        in_valid = 1'b1; in_word = w; in_texel = t[3:0];
        c0 = model[w[31:24]]; c1 = model[w[23:16]];
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " rgb"}, {8'd0, out_rgb}, {8'd0, w[t] ? c1 : c0});
        check("R8 cand0", {8'd0, out_cand0}, {8'd0, c0});
        check("R8 cand1", {8'd0, out_cand1}, {8'd0, c1});
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [31:0] prev_w;
        int          prev_t;
        bit          prev_v;
        // R1: during reset
        #3;
        check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        check("R1 rgb in reset", {8'd0, out_rgb}, 32'd0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
        check("R1 cands after reset", {8'd0, out_cand0 | out_cand1}, 32'd0);

        // Fill palette (R6)
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = a[7:0]; wr_data = pal_val(a);
            model[a] = pal_val(a);
        end
        @(negedge clk);
        wr_en = 1'b0;

        // R3/R4: sweep all texels over many cells
        lfsr = 32'hACE1_1234;
        for (int c = 0; c < 48; c++) begin
            for (int t = 0; t < 16; t++) begin
                decode_one(lfsr, t, "R4");
            end
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        end
        // R3 field positions: distinct indices, all-zero and all-one selections
        decode_one({8'h12, 8'hE7, 16'h0000}, 5, "R3 idx0");
        decode_one({8'h12, 8'hE7, 16'hFFFF}, 5, "R3 idx1");
        decode_one({8'h33, 8'h33, 16'hA5A5}, 0, "R3 equal");
        // R4 row-major: texel at row 2 col 3 is bit 11
        decode_one({8'h01, 8'h02, 16'h0800}, 11, "R4 row2col3");
        decode_one({8'h01, 8'h02, 16'h0800}, 14, "R4 row3col2");

        // R5: idle after requests
        @(negedge clk);
        check("R5 valid idle", {31'd0, out_valid}, 32'd0);
        check("R5 rgb idle", {8'd0, out_rgb | out_cand0 | out_cand1}, 32'd0);

        // R7: same-edge write and read to entry 7 returns the old value
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'd7; wr_data = 24'hC0FFEE;
        in_valid = 1'b1; in_word = {8'd7, 8'd9, 16'h0000}; in_texel = 4'd3;
        @(negedge clk);
        wr_en = 1'b0; in_valid = 1'b0;
        check("R7 old value", {8'd0, out_rgb}, {8'd0, model[7]});
        model[7] = 24'hC0FFEE;
        // R6: later read sees the new value
        decode_one({8'd7, 8'd9, 16'h0000}, 3, "R6 new value");
        decode_one({8'd9, 8'd7, 16'h0008}, 3, "R6 new value idx1");

        // R9: back-to-back stream, checked one cycle behind
        prev_v = 1'b0; prev_w = '0; prev_t = 0;
        lfsr = 32'h1357_9BDF;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (prev_v) begin
                check("R9 stream valid", {31'd0, out_valid}, 32'd1);
                check("R9 stream rgb", {8'd0, out_rgb},
                      {8'd0, prev_w[prev_t] ? model[prev_w[23:16]] : model[prev_w[31:24]]});
            end
            in_valid = 1'b1; in_word = lfsr; in_texel = lfsr[7:4] ^ lfsr[27:24];
            prev_v = 1'b1; prev_w = lfsr; prev_t = int'(lfsr[7:4] ^ lfsr[27:24]);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 last rgb", {8'd0, out_rgb},
              {8'd0, prev_w[prev_t] ? model[prev_w[23:16]] : model[prev_w[31:24]]});
        @(negedge clk);
        check("R2 drop", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule